// File: doc/BRIEF.md
# Smart Card Transmit Queue with Error Lockout

This block holds the characters that are waiting to be sent to a smart card. Bus-side logic pushes bytes into a small circular store. The character transmitter pulls them out in arrival order through a valid/request pair. The block reports its fill count, empty and full flags, and a low-water (tide) interrupt. The tide interrupt is raised while the count is below a threshold that software programs, so a driver can refill the queue before it runs dry.

The protocol engine pulses an error input when a character fails to go out under the T=0 protocol. The block latches that event as a sticky error interrupt, which is bit 4 of the interrupt status word. From then on it stops offering data, and transmitter requests are ignored. Writes are still taken in, so software can keep staging characters. Only a flush clears the condition. A flush empties the queue and drops the error in one cycle, and the transmitter sees data again only after new characters are written.

Top module: `sc_txq`

## Requirements
- R1: In the cycle after a synchronous reset, `level` is 0, `empty` is 1, `full` is 0, `rd_valid` is 0 and `err_irq` is 0.
- R2: Characters leave in write order. While `rd_valid` is 1, `rd_data` shows the oldest stored character, and a clock edge with `rd_req` high removes it.
- R3: A write presented while `full` is 1 is discarded. Only an accepted read in the same cycle changes `level`.
- R4: `level` counts stored characters (0 to DEPTH) and is updated at each edge. `empty` is 1 exactly when it is 0 and `full` is 1 exactly when it is DEPTH.
- R5: At every edge `tide_irq` is loaded with (new level < `tide_thr`), using the threshold presented at that edge.
- R6: An edge with `tx_err` high and `flush` low sets `err_irq`, and it stays set until a flush.
- R7: While `err_irq` is 1, `rd_valid` is 0 and `rd_req` has no effect on `level` or on the stored data.
- R8: While `err_irq` is 1, writes to a queue that is not full are still accepted and raise `level`.
- R9: An edge with `flush` high leaves `level` 0, `empty` 1 and `err_irq` 0 in the next cycle.
- R10: `flush` overrides everything else in the same cycle. A concurrent write is dropped, a concurrent read removes nothing, and a concurrent `tx_err` does not set `err_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from bus side |
| wr_data | input | DW (8) | Character to store |
| rd_req | input | 1 | Transmitter takes the offered character |
| flush | input | 1 | Empty the queue and clear the error |
| tx_err | input | 1 | Failed T=0 character from protocol engine |
| tide_thr | input | LW (4) | Low-water threshold |
| rd_data | output | DW (8) | Oldest stored character |
| rd_valid | output | 1 | Character offered to transmitter |
| level | output | LW (4) | Number of stored characters |
| empty | output | 1 | Queue holds nothing |
| full | output | 1 | Queue holds DEPTH characters |
| tide_irq | output | 1 | Level below threshold |
| err_irq | output | 1 | Sticky transmit error (status bit 4) |

## Verification
Two collisions are probed. A write and a read can land on the same edge at the full boundary, and a flush can coincide with a write, a read and a `tx_err` pulse. Directed steps force both cases: a write plus a read at full, and a flush with an error pulse and a write. Seeded random traffic then makes them recur at irregular points. In every cycle, a queue model in the bench predicts level, flags, interrupts and the offered character from the stated priorities, and the outputs are compared with it.

// File: rtl/sc_txq_pkg.sv
package sc_txq_pkg;
  // per-cycle queue operation after priority resolution
  typedef struct packed {
    logic clr;
    logic push;
    logic pop;
  } txq_op_t;
endpackage

// File: rtl/sc_txq_store.sv
module sc_txq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [PW-1:0] ra,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // show-ahead read so the head character is present with rd_valid
  assign rd = mem[ra];
endmodule

// File: rtl/sc_txq_ptrs.sv
module sc_txq_ptrs
  import sc_txq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  txq_op_t       op,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [LW-1:0] level,
  output logic [LW-1:0] lvl_nxt,
  output logic          empty,
  output logic          full
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [LW-1:0] TOP  = LW'(DEPTH);

  function automatic logic [PW-1:0] advance(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (rst || op.clr) lvl_nxt = '0;
    else               lvl_nxt = level + LW'(op.push) - LW'(op.pop);
  end

  always_ff @(posedge clk) begin
    if (rst || op.clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (op.push) wr_ptr <= advance(wr_ptr);
      if (op.pop)  rd_ptr <= advance(rd_ptr);
    end
    level <= lvl_nxt;
    empty <= (lvl_nxt == '0);
    full  <= (lvl_nxt == TOP);
  end
endmodule

// File: rtl/sc_txq_lock.sv
module sc_txq_lock #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          err_in,
  input  logic [LW-1:0] lvl_nxt,
  input  logic [LW-1:0] thr,
  output logic          err_q,
  output logic          tide_q
);
  always_ff @(posedge clk) begin
    if (rst || clr)  err_q <= 1'b0;
    else if (err_in) err_q <= 1'b1;
    // lvl_nxt is forced to zero during reset, so no reset branch is needed
    tide_q <= (lvl_nxt < thr);
  end
endmodule

// File: rtl/sc_txq.sv
module sc_txq
  import sc_txq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic          flush,
  input  logic          tx_err,
  input  logic [LW-1:0] tide_thr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          tide_irq,
  output logic          err_irq
);
  txq_op_t       op;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] lvl_nxt;

  assign rd_valid = !empty && !err_irq;

  always_comb begin
    op.clr  = flush;
    op.push = wr_en  && !full     && !flush;
    op.pop  = rd_req && rd_valid  && !flush;
  end

  sc_txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk (clk),
    .we  (op.push),
    .wa  (wr_ptr),
    .wd  (wr_data),
    .ra  (rd_ptr),
    .rd  (rd_data)
  );

  sc_txq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .level   (level),
    .lvl_nxt (lvl_nxt),
    .empty   (empty),
    .full    (full)
  );

  sc_txq_lock #(.LW(LW)) u_lock (
    .clk     (clk),
    .rst     (rst),
    .clr     (flush),
    .err_in  (tx_err),
    .lvl_nxt (lvl_nxt),
    .thr     (tide_thr),
    .err_q   (err_irq),
    .tide_q  (tide_irq)
  );
endmodule

// File: rtl/sc_txq_chk.sv
module sc_txq_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_req,
  input logic          flush,
  input logic          tx_err,
  input logic [LW-1:0] tide_thr,
  input logic [LW-1:0] level,
  input logic          empty,
  input logic          full,
  input logic          rd_valid,
  input logic          tide_irq,
  input logic          err_irq
);
  localparam logic [LW-1:0] TOP = LW'(DEPTH);

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (level <= TOP) && (full == (level == TOP)) && (empty == (level == '0)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    full && wr_en && !flush && !(rd_req && rd_valid) |=> level == TOP);

  assert_pop_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_valid && !wr_en && !flush |=> level == $past(level) - 1'b1);

  assert_tide_R5: assert property (@(posedge clk) disable iff (rst)
    tide_irq == (level < $past(tide_thr)));

  assert_err_set_R6: assert property (@(posedge clk) disable iff (rst)
    tx_err && !flush |=> err_irq);

  assert_err_hold_R6: assert property (@(posedge clk) disable iff (rst)
    err_irq && !flush |=> err_irq);

  assert_lockout_R7: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> !rd_valid);

  assert_lock_level_R7: assert property (@(posedge clk) disable iff (rst)
    err_irq && !wr_en && !flush |=> level == $past(level));

  assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level == '0) && empty && !err_irq);
endmodule

bind sc_txq sc_txq_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_req   (rd_req),
  .flush    (flush),
  .tx_err   (tx_err),
  .tide_thr (tide_thr),
  .level    (level),
  .empty    (empty),
  .full     (full),
  .rd_valid (rd_valid),
  .tide_irq (tide_irq),
  .err_irq  (err_irq)
);

// File: tb/sc_txq_bench.sv
`timescale 1ns/1ps
module sc_txq_bench;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int LW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_req = 1'b0, flush = 1'b0, tx_err = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [LW-1:0] tide_thr = 4'd3;
  logic [DW-1:0] rd_data;
  logic          rd_valid, empty, full, tide_irq, err_irq;
  logic [LW-1:0] level;

  sc_txq u_sc_txq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_req(rd_req),
    .flush(flush), .tx_err(tx_err), .tide_thr(tide_thr), .rd_data(rd_data),
    .rd_valid(rd_valid), .level(level), .empty(empty), .full(full),
    .tide_irq(tide_irq), .err_irq(err_irq)
  );

  int total = 0;
  int bad = 0;
  logic [DW-1:0] mq [DEPTH];
  int  mcnt = 0;
  bit  merr = 0;
  bit  mtide = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_valid();
    return (mcnt > 0) && !merr;
  endfunction

  task automatic check_all();
    chk("R4", "level", 32'(level), 32'(mcnt));
    chk("R4", "empty", 32'(empty), 32'(mcnt == 0));
    chk("R4", "full",  32'(full),  32'(mcnt == DEPTH));
    chk("R6", "err_irq", 32'(err_irq), 32'(merr));
    chk("R5", "tide_irq", 32'(tide_irq), 32'(mtide));
    chk("R7", "rd_valid", 32'(rd_valid), 32'(exp_valid()));
    if (exp_valid()) chk("R2", "rd_data", 32'(rd_data), 32'(mq[0]));
  endtask

  // drive one cycle of inputs, advance the model, check after the edge
  task automatic step(input bit w, input logic [DW-1:0] d, input bit r,
                      input bit f, input bit e, input logic [LW-1:0] t);
    bit push, pop;
    wr_en = w; wr_data = d; rd_req = r; flush = f; tx_err = e; tide_thr = t;
    push = w && (mcnt < DEPTH) && !f;
    pop  = r && exp_valid() && !f;
    @(posedge clk);
    if (f) begin
      mcnt = 0;
      merr = 0;
    end else begin
      if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
        mcnt--;
      end
      if (push) begin
        mq[mcnt] = d;
        mcnt++;
      end
      if (e) merr = 1;
    end
    mtide = (mcnt < int'(t));
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #750000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    rv = $urandom(32'h5A17_C0DE);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "level", 32'(level), 0);
    chk("R1", "empty", 32'(empty), 1);
    chk("R1", "full", 32'(full), 0);
    chk("R1", "rd_valid", 32'(rd_valid), 0);
    chk("R1", "err_irq", 32'(err_irq), 0);
    mtide = (0 < int'(tide_thr));
    rst = 1'b0;

    // fill to the top
    for (int i = 0; i < DEPTH; i++) step(1, 8'hA0 + 8'(i), 0, 0, 0, 4'd3);
    // R3: write while full, no read
    step(1, 8'hEE, 0, 0, 0, 4'd3);
    chk("R3", "level after dropped write", 32'(level), DEPTH);
    // R3: write while full with a read in the same cycle
    step(1, 8'hEF, 1, 0, 0, 4'd3);
    chk("R3", "level write+read at full", 32'(level), DEPTH - 1);
    // R2: drain a few in order
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 4'd6);
    chk("R2", "head after drain", 32'(rd_data), 32'h A4);
    // R6: error pulse
    step(0, 0, 0, 0, 1, 4'd6);
    chk("R6", "err latched", 32'(err_irq), 1);
    // R7: requests ignored during error
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 4'd6);
    chk("R7", "level held in error", 32'(level), 4);
    chk("R7", "no valid in error", 32'(rd_valid), 0);
    // R8: writes accepted during error
    step(1, 8'h55, 0, 0, 0, 4'd6);
    chk("R8", "level after write in error", 32'(level), 5);
    // R10: flush with write, read and error in the same cycle
    step(1, 8'h66, 1, 1, 1, 4'd6);
    chk("R10", "level after flush collision", 32'(level), 0);
    chk("R10", "err after flush collision", 32'(err_irq), 0);
    // R9: data flows again after refill
    step(1, 8'h77, 0, 0, 0, 4'd1);
    chk("R9", "valid after flush+write", 32'(rd_valid), 1);
    chk("R9", "data after flush+write", 32'(rd_data), 32'h77);
    // R9: flush from an error state alone
    step(0, 0, 0, 0, 1, 4'd1);
    step(0, 0, 0, 1, 0, 4'd1);
    chk("R9", "err cleared by flush", 32'(err_irq), 0);
    chk("R9", "empty after flush", 32'(empty), 1);

    // seeded random traffic
    for (int n = 0; n < 3000; n++) begin
      bit w, r, f, e;
      logic [LW-1:0] t;
      w = ($urandom % 100) < 55;
      r = ($urandom % 100) < 45;
      f = ($urandom % 40) == 0;
      e = ($urandom % 60) == 0;
      t = ($urandom % 30 == 0) ? LW'($urandom % (DEPTH + 2)) : tide_thr;
      step(w, 8'($urandom), r, f, e, t);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule